// File: doc/BRIEF.md
# HDLC Receive Deframer with In-Queue Frame Status

This block takes a serial bit stream from a time-slot gate and recovers bit-synchronous HDLC frames from it. Each bit arrives with a one-cycle strobe. The block hunts for the flag pattern and removes the zeros inserted after runs of five ones. It checks the 16-bit frame check sequence and puts the payload bytes into a receive queue. The two check bytes are never stored. After the last payload byte of a frame it appends one status byte in line with the data, so a host draining the queue sees the frame boundary. A ninth tag bit travels with every entry to mark which entries are status bytes.

The host pops the queue one byte at a time. It can watch the queue depth, an end-of-frame indicator and a level interrupt with a programmable threshold. Overrun, idle-line and match-character events are held in sticky flags until the host acknowledges them with a status-read strobe. A transparent mode turns off all framing: every eight received bits become one stored byte. In this mode an optional comparator flags a chosen character when it appears.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: In framed mode, after the last payload byte of a frame the block stores one entry with `rd_is_stat`=1. Its bits 5..0 are zero. The two check-sequence bytes are never stored.
- R2: Status bit 7 is 1 when the frame check fails and 0 when it passes. The check is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, run over payload and check bytes, and it passes on residue 0xF0B8. A closing flag that is not on a byte boundary also sets bit 7.
- R3: `q_count` equals the number of stored entries, from 0 to 64, and changes by at most one per cycle.
- R4: `eof_present` and `irq_eof` are 1 exactly while at least one status entry is in the queue.
- R5: `irq_fill` is 1 exactly while `q_count` is greater than `fill_lvl`.
- R6: A byte arriving when the queue holds 64 entries is dropped and sets `ovr_flag`. The flag stays set until a `stat_rd` pulse.
- R7: In framed mode, fifteen consecutive ones set `idle_flag`, which stays set until a `stat_rd` pulse.
- R8: While `rx_en` is 0, strobed bits have no effect on the queue, and framing restarts from hunt when the receiver is enabled again.
- R9: In transparent mode each group of eight bits is stored unchanged, least significant bit first. No flag detection, zero removal, check or status entry takes place.
- R10: In transparent mode with `match_en`=1, a stored byte equal to `match_chr` sets `match_hit`, which stays set until a `stat_rd` pulse.
- R11: Bits are packed least significant first. A 0 that follows five consecutive 1s is discarded.
- R12: Seven consecutive ones abort the frame in progress. If the frame had already stored a payload byte, a status entry of 0xC0 follows it.
- R13: A frame with fewer than three bytes between flags stores nothing, not even a status entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| bit_vld | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial data bit |
| xparent | input | 1 | 1 selects transparent mode, 0 framed mode |
| match_en | input | 1 | Enables match-character detection |
| match_chr | input | 8 | Character to detect in transparent mode |
| fill_lvl | input | 6 | Queue depth threshold for `irq_fill` |
| rd_req | input | 1 | Pops the head entry when the queue is non-empty |
| stat_rd | input | 1 | Clears the sticky flags |
| rd_data | output | 8 | Head entry data |
| rd_is_stat | output | 1 | Head entry is a status byte |
| q_count | output | 7 | Number of stored entries |
| eof_present | output | 1 | At least one status entry is queued |
| irq_fill | output | 1 | Fill-level interrupt |
| irq_eof | output | 1 | End-of-frame interrupt |
| ovr_flag | output | 1 | Sticky overrun |
| idle_flag | output | 1 | Sticky idle line |
| match_hit | output | 1 | Sticky match character seen |

## Verification
The bound checker watches properties that must hold on every cycle. The queue depth stays within range and moves by at most one entry per cycle. An end-of-frame indication never appears with an empty queue. A queued status entry always has zero low bits. The overrun and idle flags cannot drop without an acknowledge. A receiver held disabled never grows the queue. Only the bench scenarios can show the content-dependent behaviour: correct destuffing of runs of ones, the check-sequence verdict for good and corrupted frames, abort and short-frame handling, transparent packing with the match detector, and the exact fill and overrun boundaries at 11 and 65 bytes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   localparam int BYTE_W = 8;
   localparam int ENTRY_W = BYTE_W + 1;

   localparam logic [3:0] RUN_STUFF = 4'd5;
   localparam logic [3:0] RUN_FLAG  = 4'd6;
   localparam logic [3:0] RUN_ABORT = 4'd7;
   localparam logic [3:0] RUN_IDLE  = 4'd15;

   localparam logic [15:0] CRC_SEED = 16'hFFFF;
   localparam logic [15:0] CRC_POLY = 16'h8408;
   localparam logic [15:0] CRC_GOOD = 16'hF0B8;

   localparam logic [7:0] STAT_OK    = 8'h00;
   localparam logic [7:0] STAT_BAD   = 8'h80;
   localparam logic [7:0] STAT_ABORT = 8'hC0;

   typedef struct packed {
      logic              vld;
      logic              tag;
      logic [BYTE_W-1:0] dat;
   } q_wr_t;

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
   import hdlc_rx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        xparent,
   input  logic        bit_vld,
   input  logic        bit_in,
   input  logic        match_en,
   input  logic [7:0]  match_chr,
   output q_wr_t       wr,
   output logic        idle_evt,
   output logic        match_evt
);

   logic [3:0]  ones_q, ones_inc;
   logic [7:0]  sr_q, sr_nxt;
   logic [2:0]  bcnt_q;
   logic [1:0]  nbyte_q;
   logic        in_frame_q;
   logic [15:0] crc_q, crc_nxt;
   logic [7:0]  hold0_q, hold1_q;
   logic        do_push, byte_done, is_flag, is_abort, is_idle;

   always_comb begin
      ones_inc  = (ones_q == RUN_IDLE) ? RUN_IDLE : ones_q + 4'd1;
      sr_nxt    = {bit_in, sr_q[7:1]};
      crc_nxt   = crc_step(crc_q, sr_nxt);
      is_flag   = !xparent && !bit_in && (ones_q == RUN_FLAG);
      is_abort  = !xparent && bit_in && (ones_inc == RUN_ABORT);
      is_idle   = !xparent && bit_in && (ones_inc == RUN_IDLE);
      if (xparent)     do_push = 1'b1;
      else if (bit_in) do_push = in_frame_q && (ones_inc < RUN_ABORT);
      else             do_push = in_frame_q && (ones_q != RUN_STUFF) && (ones_q != RUN_FLAG);
      byte_done = do_push && (bcnt_q == 3'd7);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q     <= '0;
         sr_q       <= '0;
         bcnt_q     <= '0;
         nbyte_q    <= '0;
         in_frame_q <= 1'b0;
         crc_q      <= CRC_SEED;
         hold0_q    <= '0;
         hold1_q    <= '0;
         wr         <= '0;
         idle_evt   <= 1'b0;
         match_evt  <= 1'b0;
      end else begin
         wr.vld    <= 1'b0;
         idle_evt  <= 1'b0;
         match_evt <= 1'b0;
         if (!en) begin
            in_frame_q <= 1'b0;
            bcnt_q     <= '0;
            ones_q     <= '0;
         end else if (bit_vld) begin
            if (!xparent) ones_q <= bit_in ? ones_inc : 4'd0;
            if (do_push) begin
               sr_q   <= sr_nxt;
               bcnt_q <= bcnt_q + 3'd1;
            end
            if (byte_done && xparent) begin
               wr        <= '{vld: 1'b1, tag: 1'b0, dat: sr_nxt};
               match_evt <= match_en && (sr_nxt == match_chr);
            end
            if (byte_done && !xparent) begin
               crc_q   <= crc_nxt;
               hold0_q <= sr_nxt;
               hold1_q <= hold0_q;
               if (nbyte_q != 2'd3) nbyte_q <= nbyte_q + 2'd1;
               if (nbyte_q >= 2'd2) wr <= '{vld: 1'b1, tag: 1'b0, dat: hold1_q};
            end
            if (is_flag) begin
               if (in_frame_q && nbyte_q == 2'd3)
                  wr <= '{vld: 1'b1, tag: 1'b1,
                          dat: ((crc_q != CRC_GOOD) || (bcnt_q != 3'd7)) ? STAT_BAD : STAT_OK};
               in_frame_q <= 1'b1;
               bcnt_q     <= '0;
               nbyte_q    <= '0;
               crc_q      <= CRC_SEED;
            end
            if (is_abort) begin
               if (in_frame_q && nbyte_q == 2'd3)
                  wr <= '{vld: 1'b1, tag: 1'b1, dat: STAT_ABORT};
               in_frame_q <= 1'b0;
            end
            if (is_idle) idle_evt <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
   parameter  int DEPTH = 64,
   parameter  int W     = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_dat,
   input  logic          rd_en,
   output logic [W-1:0]  rd_dat,
   output logic [CW-1:0] count,
   output logic          full
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic          wr_ok, rd_ok;

   assign full   = (count == CW'(DEPTH));
   assign wr_ok  = wr_en && !full;
   assign rd_ok  = rd_en && (count != '0);
   assign rd_dat = mem[rptr_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr_q] <= wr_dat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wptr_q <= wptr_q + AW'(1);
         if (rd_ok) rptr_q <= rptr_q + AW'(1);
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             xparent,
   input  logic             match_en,
   input  logic [7:0]       match_chr,
   input  logic [THR_W-1:0] fill_lvl,
   input  logic             rd_req,
   input  logic             stat_rd,
   output logic [7:0]       rd_data,
   output logic             rd_is_stat,
   output logic [CW-1:0]    q_count,
   output logic             eof_present,
   output logic             irq_fill,
   output logic             irq_eof,
   output logic             ovr_flag,
   output logic             idle_flag,
   output logic             match_hit
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("hdlc_rx_deframer: DEPTH must be a power of two and at least 4");
   end

   localparam int NFLG = 3;

   q_wr_t             pkt;
   logic              idle_evt, match_evt, ovr_evt;
   logic              q_full, wr_ok, rd_ok;
   logic [ENTRY_W-1:0] head;
   logic [CW-1:0]     nfrm_q;
   logic [NFLG-1:0]   flg_set, flg_q;

   hdlc_rx_bitproc u_bitproc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en),
      .xparent   (xparent),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .match_en  (match_en),
      .match_chr (match_chr),
      .wr        (pkt),
      .idle_evt  (idle_evt),
      .match_evt (match_evt)
   );

   hdlc_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pkt.vld),
      .wr_dat ({pkt.tag, pkt.dat}),
      .rd_en  (rd_req),
      .rd_dat (head),
      .count  (q_count),
      .full   (q_full)
   );

   assign wr_ok      = pkt.vld && !q_full;
   assign rd_ok      = rd_req && (q_count != '0);
   assign ovr_evt    = pkt.vld && q_full;
   assign rd_data    = head[7:0];
   assign rd_is_stat = head[8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nfrm_q <= '0;
      end else begin
         case ({wr_ok && pkt.tag, rd_ok && head[8]})
            2'b10:   nfrm_q <= nfrm_q + CW'(1);
            2'b01:   nfrm_q <= nfrm_q - CW'(1);
            default: nfrm_q <= nfrm_q;
         endcase
      end
   end

   assign eof_present = (nfrm_q != '0);
   assign irq_eof     = eof_present;
   assign irq_fill    = (q_count > CW'(fill_lvl));

   assign flg_set = {match_evt, idle_evt, ovr_evt};

   for (genvar g = 0; g < NFLG; g++) begin : g_sticky
      logic held_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          held_q <= 1'b0;
         else if (flg_set[g]) held_q <= 1'b1;
         else if (stat_rd)    held_q <= 1'b0;
      end
      assign flg_q[g] = held_q;
   end

   assign ovr_flag  = flg_q[0];
   assign idle_flag = flg_q[1];
   assign match_hit = flg_q[2];

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
   parameter  int DEPTH = 64,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          stat_rd,
   input logic [7:0]    rd_data,
   input logic          rd_is_stat,
   input logic [CW-1:0] q_count,
   input logic          eof_present,
   input logic          ovr_flag,
   input logic          idle_flag
);

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH)); // R3

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(q_count) <= int'($past(q_count)) + 1) && (int'($past(q_count)) <= int'(q_count) + 1)); // R3

   AST_EOF_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      eof_present |-> (q_count != '0)); // R4

   AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_count != '0) && rd_is_stat) |-> (rd_data[5:0] == 6'd0)); // R1

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !stat_rd) |=> ovr_flag); // R6

   AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_flag && !stat_rd) |=> idle_flag); // R7

   AST_DISABLED_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !$past(rx_en) && !$past(rx_en, 2)) |-> (q_count <= $past(q_count))); // R8

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en       (rx_en),
   .stat_rd     (stat_rd),
   .rd_data     (rd_data),
   .rd_is_stat  (rd_is_stat),
   .q_count     (q_count),
   .eof_present (eof_present),
   .ovr_flag    (ovr_flag),
   .idle_flag   (idle_flag)
);

// File: tb/hdlc_rx_deframer_bench.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, xparent = 1'b0;
   logic       match_en = 1'b0;
   logic [7:0] match_chr = 8'h00;
   logic [5:0] fill_lvl = 6'd0;
   logic       rd_req = 1'b0, stat_rd = 1'b0;
   logic [7:0] rd_data;
   logic       rd_is_stat, eof_present, irq_fill, irq_eof, ovr_flag, idle_flag, match_hit;
   logic [6:0] q_count;

   int ntot = 0, nbad = 0;
   logic [3:0] run_ones = '0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   hdlc_rx_deframer u_hdlc_rx_deframer (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
      .xparent(xparent), .match_en(match_en), .match_chr(match_chr), .fill_lvl(fill_lvl),
      .rd_req(rd_req), .stat_rd(stat_rd), .rd_data(rd_data), .rd_is_stat(rd_is_stat),
      .q_count(q_count), .eof_present(eof_present), .irq_fill(irq_fill), .irq_eof(irq_eof),
      .ovr_flag(ovr_flag), .idle_flag(idle_flag), .match_hit(match_hit)
   );

   typedef struct packed {
      logic [31:0] pay;
      logic [2:0]  len;
      logic        bad;
      logic [7:0]  st;
   } vec_t;

   localparam vec_t TBL [4] = '{
      '{pay: 32'h0000_3412, len: 3'd2, bad: 1'b0, st: 8'h00},
      '{pay: 32'h007E_FFFF, len: 3'd3, bad: 1'b0, st: 8'h00},
      '{pay: 32'h0000_0000, len: 3'd1, bad: 1'b0, st: 8'h00},
      '{pay: 32'hC33C_5AA5, len: 3'd4, bad: 1'b1, st: 8'h80}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      ntot++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = b;
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_flag();
      for (int i = 0; i < 8; i++) send_bit((i == 0 || i == 7) ? 1'b0 : 1'b1);
      run_ones = '0;
   endtask

   task automatic send_stuffed(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         send_bit(b[i]);
         run_ones = b[i] ? run_ones + 4'd1 : 4'd0;
         if (run_ones == 4'd5) begin
            send_bit(1'b0);
            run_ones = '0;
         end
      end
   endtask

   task automatic send_plain(input logic [7:0] b);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
   endtask

   function automatic logic [15:0] fcs_of(input logic [31:0] pay, input int len);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int k = 0; k < len; k++)
         for (int i = 0; i < 8; i++)
            c = (c[0] ^ pay[8*k+i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      return ~c;
   endfunction

   task automatic send_frame(input logic [31:0] pay, input int len, input logic bad);
      logic [15:0] f;
      f = fcs_of(pay, len);
      if (bad) f = f ^ 16'h0001;
      send_flag();
      for (int k = 0; k < len; k++) send_stuffed(pay[8*k +: 8]);
      send_stuffed(f[7:0]);
      send_stuffed(f[15:8]);
      send_flag();
      repeat (4) @(negedge clk);
   endtask

   task automatic pop_chk(input string req, input logic [7:0] exp_d, input logic exp_t);
      @(negedge clk);
      chk(req, 32'(rd_data), 32'(exp_d));
      chk(req, 32'(rd_is_stat), 32'(exp_t));
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic pulse_stat();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++;
         ntot++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", ntot, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R3 reset count", 32'(q_count), 0);
      chk("R4 reset eof", 32'(eof_present), 0);
      chk("R5 reset irq_fill", 32'(irq_fill), 0);
      chk("R6 reset ovr", 32'(ovr_flag), 0);
      chk("R7 reset idle", 32'(idle_flag), 0);

      rx_en = 1'b1;
      fill_lvl = 6'd63;
      // table of frames: R1 R2 R11
      for (int v = 0; v < 4; v++) begin
         send_frame(TBL[v].pay, int'(TBL[v].len), TBL[v].bad);
         chk("R3 frame count", 32'(q_count), 32'(TBL[v].len) + 1);
         chk("R4 eof queued", 32'(eof_present), 1);
         chk("R4 irq_eof", 32'(irq_eof), 1);
         for (int k = 0; k < int'(TBL[v].len); k++)
            pop_chk("R11 payload byte", TBL[v].pay[8*k +: 8], 1'b0);
         pop_chk("R2 R1 status byte", TBL[v].st, 1'b1);
         chk("R4 eof cleared", 32'(eof_present), 0);
      end

      // R13 short frame
      send_flag();
      send_stuffed(8'h55);
      send_stuffed(8'hAA);
      send_flag();
      repeat (4) @(negedge clk);
      chk("R13 short frame count", 32'(q_count), 0);
      chk("R13 short frame eof", 32'(eof_present), 0);

      // R12 abort after three bytes
      send_flag();
      send_stuffed(8'h31);
      send_stuffed(8'h32);
      send_stuffed(8'h33);
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      send_bit(1'b0);
      repeat (4) @(negedge clk);
      chk("R12 abort count", 32'(q_count), 2);
      pop_chk("R12 abort data", 8'h31, 1'b0);
      pop_chk("R12 abort status", 8'hC0, 1'b1);

      // R7 idle line
      for (int i = 0; i < 15; i++) send_bit(1'b1);
      repeat (3) @(negedge clk);
      chk("R7 idle set", 32'(idle_flag), 1);
      repeat (5) @(negedge clk);
      chk("R7 idle held", 32'(idle_flag), 1);
      pulse_stat();
      @(negedge clk);
      chk("R7 idle cleared", 32'(idle_flag), 0);
      send_bit(1'b0);

      // R8 disabled receiver ignores a whole frame
      rx_en = 1'b0;
      send_frame(32'h0000_2211, 2, 1'b0);
      chk("R8 disabled count", 32'(q_count), 0);
      chk("R8 disabled eof", 32'(eof_present), 0);

      // R9 R10 transparent mode
      xparent = 1'b1;
      match_en = 1'b1;
      match_chr = 8'h7E;
      @(negedge clk);
      rx_en = 1'b1;
      send_plain(8'h11);
      repeat (4) @(negedge clk);
      chk("R10 no match yet", 32'(match_hit), 0);
      send_plain(8'h7E);
      send_plain(8'hC4);
      repeat (4) @(negedge clk);
      chk("R9 transparent count", 32'(q_count), 3);
      chk("R10 match seen", 32'(match_hit), 1);
      chk("R9 no status entry", 32'(eof_present), 0);
      pop_chk("R9 raw byte", 8'h11, 1'b0);
      pop_chk("R9 raw flag pattern", 8'h7E, 1'b0);
      pop_chk("R9 raw byte", 8'hC4, 1'b0);
      pulse_stat();
      @(negedge clk);
      chk("R10 match cleared", 32'(match_hit), 0);

      // R5 R6 fill level and overrun
      match_en = 1'b0;
      fill_lvl = 6'd10;
      for (int i = 1; i <= 10; i++) send_plain(8'(i));
      repeat (4) @(negedge clk);
      chk("R5 at threshold", 32'(irq_fill), 0);
      send_plain(8'd11);
      repeat (4) @(negedge clk);
      chk("R5 above threshold", 32'(irq_fill), 1);
      fill_lvl = 6'd63;
      for (int i = 12; i <= 64; i++) send_plain(8'(i));
      repeat (4) @(negedge clk);
      chk("R3 full count", 32'(q_count), 64);
      chk("R5 full irq", 32'(irq_fill), 1);
      chk("R6 no overrun yet", 32'(ovr_flag), 0);
      send_plain(8'd65);
      repeat (4) @(negedge clk);
      chk("R6 overrun set", 32'(ovr_flag), 1);
      chk("R6 count capped", 32'(q_count), 64);
      repeat (6) @(negedge clk);
      chk("R6 overrun held", 32'(ovr_flag), 1);
      pulse_stat();
      @(negedge clk);
      chk("R6 overrun cleared", 32'(ovr_flag), 0);
      pop_chk("R6 oldest kept", 8'd1, 1'b0);
      chk("R3 after pop", 32'(q_count), 63);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

endmodule